// File: doc/BRIEF.md
# Serial Port Status and Control Register Front End

This block is the register-side front end of an asynchronous serial port that has a receive FIFO. A simple bus reaches it: one access per cycle, a byte offset, 16-bit write data, and read data that comes back one cycle after the read strobe. It holds the line-format (mode), bit-rate, control, FIFO-control and port-pin registers. It presents their values to the serial engine next to it.

The block keeps five status flags. The serial engine sets three of them through event inputs: receive-ready, data-ready and break. Software clears a flag by writing a zero to its bit. The block also drives the transmit and receive interrupt lines. A write to the transmit-data offset goes out as a one-cycle strobe with the byte. A read of the receive-data offset takes the head byte of an external FIFO and pops it. The receive trigger level is decoded from the FIFO-control register and sent to the FIFO, together with a flush pulse.

Top module: `serreg_top`

## Requirements
- R1: After reset the flags transmit-end and transmit-empty are 1 and all other flags are 0. Bit rate is 0xFF, control is 0x20, and mode, port and FIFO control are 0. Both interrupt lines are 0.
- R2: Writes store a masked value. Mode (offset 0x00) keeps bits selected by 0x7B. Control (0x08) keeps bits selected by 0xFA. Port (0x20) keeps bits selected by 0xF3. Bit rate (0x04) keeps all 8 bits and FIFO control (0x18) keeps all 16 bits. Each of these offsets reads back the stored value.
- R3: A read of status (0x10) returns transmit-end in bit 6, transmit-empty in bit 5, break in bit 4, receive-ready in bit 1 and data-ready in bit 0, with every other bit 0. Read data and its valid flag appear on the cycle after the read strobe. The read data is 0 in cycles with no read.
- R4: A status write clears each flag whose bit position holds 0. A flag whose bit holds 1 is left unchanged.
- R5: A status write with 0 in bit 1 or bit 0 drops the receive interrupt. A control write with bit 6 clear also drops it. A receive-ready event raises the receive-ready flag, and it raises the receive interrupt when the control bit 6 in effect that cycle is set.
- R6: A status read returns the flags as they were before the read. After that read, if control bit 5 is set, transmit-empty and transmit-end are both set.
- R7: A control write with bit 5 clear sets transmit-end. The transmit interrupt line takes bit 7 of each control write.
- R8: A write to transmit data (0x0C) gives a one-cycle transmit strobe carrying the low byte, and it clears transmit-empty.
- R9: A read of receive data (0x14) while the FIFO count is nonzero returns the FIFO head byte and asserts the pop output in the same cycle. It clears receive-ready when the count minus one is below the trigger level. With a count of 0 it returns 0 and does not pop. Offset 0x1C returns the count.
- R10: FIFO-control bits 7:6 select the trigger level: 0→1, 1→4, 2→8, 3→14. A FIFO-control write with bit 1 set gives a one-cycle flush pulse.
- R11: Line status (0x24) reads 0, and writes to it change nothing. Reads of unmapped offsets (including transmit data) return 0, and writes to them change nothing.
- R12: When an event sets a flag in the same cycle that a status write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| rxq_count | input | CNT_W | Fill level of the external receive FIFO |
| rxq_data | input | BYTE_W | Head byte of the receive FIFO |
| rxq_pop | output | 1 | Pop the FIFO head (combinational) |
| rxq_flush | output | 1 | One-cycle FIFO flush request |
| rx_trig_level | output | CNT_W | Decoded receive trigger level |
| ev_rx_ready | input | 1 | Event: set receive-ready |
| ev_rx_data | input | 1 | Event: set data-ready |
| ev_break | input | 1 | Event: set break |
| cfg_mode | output | BYTE_W | Mode register value |
| cfg_baud | output | BYTE_W | Bit-rate register value |
| cfg_ctrl | output | BYTE_W | Control register value |
| cfg_port | output | BYTE_W | Port register value |
| tx_strobe | output | 1 | Transmit byte strobe |
| tx_byte | output | BYTE_W | Latched transmit byte |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The engine's set events are independent of the bus, so a flag can be set by an event in the same cycle that a status write clears it. The receive interrupt can likewise be raised in the same cycle that a control write lowers its enable. The bench provokes both collisions on purpose, and random traffic also produces them at random. Each time, it judges the flag read back and the interrupt line against a model in which the event wins over the clear. The model also uses the control value written in that same cycle to decide the interrupt.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

  // register offsets
  localparam int OFS_MODE = 'h00;
  localparam int OFS_BAUD = 'h04;
  localparam int OFS_CTRL = 'h08;
  localparam int OFS_TXD  = 'h0C;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_RXD  = 'h14;
  localparam int OFS_FIFO = 'h18;
  localparam int OFS_CNT  = 'h1C;
  localparam int OFS_PORT = 'h20;
  localparam int OFS_LSR  = 'h24;
  localparam int NUM_REGS = 10;

  // write masks
  localparam logic [7:0] MASK_MODE = 8'h7B;
  localparam logic [7:0] MASK_CTRL = 8'hFA;
  localparam logic [7:0] MASK_PORT = 8'hF3;

  // status bit positions
  localparam int B_TEND = 6;
  localparam int B_TDE  = 5;
  localparam int B_BRK  = 4;
  localparam int B_RDF  = 1;
  localparam int B_DR   = 0;

  // control and FIFO-control bit positions
  localparam int C_TE      = 5;
  localparam int C_RIE     = 6;
  localparam int C_TIE     = 7;
  localparam int F_FLUSH   = 1;
  localparam int F_TRIG_LO = 6;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } flags_t;

  // one field per decoded offset, first field is the MSB
  typedef struct packed {
    logic mode;
    logic baud;
    logic ctrl;
    logic txd;
    logic stat;
    logic rxd;
    logic fifo;
    logic cnt;
    logic port;
    logic lsr;
  } sel_t;

  function automatic logic [7:0] pack_status(flags_t f);
    logic [7:0] s;
    s         = '0;
    s[B_TEND] = f.tend;
    s[B_TDE]  = f.tde;
    s[B_BRK]  = f.brk;
    s[B_RDF]  = f.rdf;
    s[B_DR]   = f.dr;
    return s;
  endfunction

  function automatic int trig_of(logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/serreg_decode.sv
module serreg_decode
  import serreg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);

  localparam int OFS_LIST [NUM_REGS] = '{OFS_MODE, OFS_BAUD, OFS_CTRL, OFS_TXD, OFS_STAT,
                                         OFS_RXD, OFS_FIFO, OFS_CNT, OFS_PORT, OFS_LSR};

  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[NUM_REGS-1-i] = (addr == ADDR_W'(OFS_LIST[i]));
  end

  assign sel = sel_t'(hit);

endmodule

// File: rtl/serreg_cfg.sv
module serreg_cfg
  import serreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic              wr_baud,
  input  logic              wr_ctrl,
  input  logic              wr_txd,
  input  logic              wr_fifo,
  input  logic              wr_port,
  input  logic [DATA_W-1:0] wdata,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] baud_q,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] port_q,
  output logic [DATA_W-1:0] fcr_q,
  output logic [BYTE_W-1:0] ctrl_eff,
  output logic [CNT_W-1:0]  trig,
  output logic              fifo_clr,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_irq
);

  localparam logic [BYTE_W-1:0] CTRL_RST = BYTE_W'(1) << C_TE;

  logic [BYTE_W-1:0] wbyte;
  assign wbyte = wdata[BYTE_W-1:0];

  // control value that holds for this cycle, including a write in flight
  assign ctrl_eff = wr_ctrl ? (wbyte & BYTE_W'(MASK_CTRL)) : ctrl_q;
  assign trig     = CNT_W'(trig_of(fcr_q[F_TRIG_LO +: 2]));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      baud_q   <= '1;
      ctrl_q   <= CTRL_RST;
      port_q   <= '0;
      fcr_q    <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      fifo_clr <= 1'b0;
      tx_irq   <= 1'b0;
    end else begin
      tx_valid <= wr_txd;
      fifo_clr <= wr_fifo && wdata[F_FLUSH];
      if (wr_mode) mode_q <= wbyte & BYTE_W'(MASK_MODE);
      if (wr_baud) baud_q <= wbyte;
      if (wr_ctrl) begin
        ctrl_q <= wbyte & BYTE_W'(MASK_CTRL);
        tx_irq <= wbyte[C_TIE];
      end
      if (wr_port) port_q  <= wbyte & BYTE_W'(MASK_PORT);
      if (wr_fifo) fcr_q   <= wdata;
      if (wr_txd)  tx_data <= wbyte;
    end
  end

  assert_txirq_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_ctrl)) |-> (tx_irq == $past(wbyte[C_TIE])));

  assert_txd_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_txd)) |-> (tx_valid && tx_data == $past(wbyte)));

  assert_ctrl_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~BYTE_W'(MASK_CTRL)) == '0);

  assert_flush_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_fifo)) |-> !fifo_clr);

endmodule

// File: rtl/serreg_flags.sv
module serreg_flags
  import serreg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_wr,
  input  logic             stat_rd,
  input  logic             ctrl_wr,
  input  logic             txd_wr,
  input  flags_t           keep,      // status write: 1 keeps, 0 clears
  input  logic             ctrl_te_w, // bit 5 of a control write
  input  logic             te,        // stored transmit enable
  input  logic             rie_eff,   // receive interrupt enable in effect
  input  logic             pop,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] trig,
  input  logic             ev_rdf,
  input  logic             ev_dr,
  input  logic             ev_brk,
  output flags_t           flags,
  output logic             rx_irq
);

  flags_t flags_n;
  logic   rx_irq_n;

  always_comb begin
    flags_n = flags;
    if (ctrl_wr && !ctrl_te_w) flags_n.tend = 1'b1;
    if (txd_wr) flags_n.tde = 1'b0;
    if (stat_wr) begin
      if (!keep.tend) flags_n.tend = 1'b0;
      if (!keep.tde)  flags_n.tde  = 1'b0;
      if (!keep.brk)  flags_n.brk  = 1'b0;
      if (!keep.rdf)  flags_n.rdf  = 1'b0;
      if (!keep.dr)   flags_n.dr   = 1'b0;
    end
    if (stat_rd && te) begin
      flags_n.tend = 1'b1;
      flags_n.tde  = 1'b1;
    end
    if (pop && ((cnt - CNT_W'(1)) < trig)) flags_n.rdf = 1'b0;
    // engine events win over any clear in the same cycle
    if (ev_rdf) flags_n.rdf = 1'b1;
    if (ev_dr)  flags_n.dr  = 1'b1;
    if (ev_brk) flags_n.brk = 1'b1;
  end

  always_comb begin
    rx_irq_n = rx_irq;
    if (stat_wr && (!keep.rdf || !keep.dr)) rx_irq_n = 1'b0;
    if (ctrl_wr && !rie_eff) rx_irq_n = 1'b0;
    if (ev_rdf && rie_eff) rx_irq_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '{tend: 1'b1, tde: 1'b1, default: 1'b0};
      rx_irq <= 1'b0;
    end else begin
      flags  <= flags_n;
      rx_irq <= rx_irq_n;
    end
  end

  assert_rearm_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stat_rd && te)) |-> (flags.tend && flags.tde));

  assert_event_wins_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ev_brk)) |-> flags.brk);

  assert_w0c_dr_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stat_wr && !keep.dr && !ev_dr)) |-> !flags.dr);

  assert_rxirq_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> $past(ev_rdf));

  assert_tde_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(txd_wr)) |-> !flags.tde);

endmodule

// File: rtl/serreg_rdmux.sv
module serreg_rdmux
  import serreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  sel_t              sel,
  input  logic [BYTE_W-1:0] mode_q,
  input  logic [BYTE_W-1:0] baud_q,
  input  logic [BYTE_W-1:0] ctrl_q,
  input  logic [BYTE_W-1:0] port_q,
  input  logic [DATA_W-1:0] fcr_q,
  input  logic [7:0]        status,
  input  logic [BYTE_W-1:0] rx_head,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (sel.mode) rd_val = DATA_W'(mode_q);
    if (sel.baud) rd_val = DATA_W'(baud_q);
    if (sel.ctrl) rd_val = DATA_W'(ctrl_q);
    if (sel.stat) rd_val = DATA_W'(status);
    if (sel.rxd && cnt != '0) rd_val = DATA_W'(rx_head);
    if (sel.fifo) rd_val = fcr_q;
    if (sel.cnt)  rd_val = DATA_W'(cnt);
    if (sel.port) rd_val = DATA_W'(port_q);
    if (sel.txd || sel.lsr) rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? rd_val : '0;
    end
  end

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0));

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd)) |-> rvalid);

endmodule

// File: rtl/serreg_top.sv
module serreg_top
  import serreg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [CNT_W-1:0]  rxq_count,
  input  logic [BYTE_W-1:0] rxq_data,
  output logic              rxq_pop,
  output logic              rxq_flush,
  output logic [CNT_W-1:0]  rx_trig_level,
  input  logic              ev_rx_ready,
  input  logic              ev_rx_data,
  input  logic              ev_break,
  output logic [BYTE_W-1:0] cfg_mode,
  output logic [BYTE_W-1:0] cfg_baud,
  output logic [BYTE_W-1:0] cfg_ctrl,
  output logic [BYTE_W-1:0] cfg_port,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq_tx,
  output logic              irq_rx
);

  sel_t              sel;
  flags_t            flags;
  flags_t            keep;
  logic [DATA_W-1:0] fcr_q;
  logic [BYTE_W-1:0] ctrl_eff;

  serreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  assign rxq_pop = bus_rd && sel.rxd && (rxq_count != '0);

  assign keep = '{tend: bus_wdata[B_TEND], tde: bus_wdata[B_TDE], brk: bus_wdata[B_BRK],
                  rdf: bus_wdata[B_RDF], dr: bus_wdata[B_DR]};

  serreg_cfg #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_mode (bus_wr && sel.mode),
    .wr_baud (bus_wr && sel.baud),
    .wr_ctrl (bus_wr && sel.ctrl),
    .wr_txd  (bus_wr && sel.txd),
    .wr_fifo (bus_wr && sel.fifo),
    .wr_port (bus_wr && sel.port),
    .wdata   (bus_wdata),
    .mode_q  (cfg_mode),
    .baud_q  (cfg_baud),
    .ctrl_q  (cfg_ctrl),
    .port_q  (cfg_port),
    .fcr_q   (fcr_q),
    .ctrl_eff(ctrl_eff),
    .trig    (rx_trig_level),
    .fifo_clr(rxq_flush),
    .tx_valid(tx_strobe),
    .tx_data (tx_byte),
    .tx_irq  (irq_tx)
  );

  serreg_flags #(.CNT_W(CNT_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .stat_wr  (bus_wr && sel.stat),
    .stat_rd  (bus_rd && sel.stat),
    .ctrl_wr  (bus_wr && sel.ctrl),
    .txd_wr   (bus_wr && sel.txd),
    .keep     (keep),
    .ctrl_te_w(bus_wdata[C_TE]),
    .te       (cfg_ctrl[C_TE]),
    .rie_eff  (ctrl_eff[C_RIE]),
    .pop      (rxq_pop),
    .cnt      (rxq_count),
    .trig     (rx_trig_level),
    .ev_rdf   (ev_rx_ready),
    .ev_dr    (ev_rx_data),
    .ev_brk   (ev_break),
    .flags    (flags),
    .rx_irq   (irq_rx)
  );

  serreg_rdmux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .sel    (sel),
    .mode_q (cfg_mode),
    .baud_q (cfg_baud),
    .ctrl_q (cfg_ctrl),
    .port_q (cfg_port),
    .fcr_q  (fcr_q),
    .status (pack_status(flags)),
    .rx_head(rxq_data),
    .cnt    (rxq_count),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
    rxq_pop |-> (rxq_count != '0));

  assert_decode_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  assert_lsr_write_inert_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr && sel.lsr)) |-> $stable(cfg_ctrl));

endmodule

// File: tb/serreg_top_tb_top.sv
`timescale 1ns/1ps
module serreg_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [4:0]  rxq_count = '0;
  logic [7:0]  rxq_data = '0;
  logic        rxq_pop, rxq_flush;
  logic [4:0]  rx_trig_level;
  logic        ev_rx_ready = 1'b0, ev_rx_data = 1'b0, ev_break = 1'b0;
  logic [7:0]  cfg_mode, cfg_baud, cfg_ctrl, cfg_port, tx_byte;
  logic        tx_strobe, irq_tx, irq_rx;

  always #2 clk = ~clk;

  serreg_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rxq_count(rxq_count), .rxq_data(rxq_data), .rxq_pop(rxq_pop), .rxq_flush(rxq_flush),
    .rx_trig_level(rx_trig_level), .ev_rx_ready(ev_rx_ready), .ev_rx_data(ev_rx_data),
    .ev_break(ev_break), .cfg_mode(cfg_mode), .cfg_baud(cfg_baud), .cfg_ctrl(cfg_ctrl),
    .cfg_port(cfg_port), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq_tx(irq_tx),
    .irq_rx(irq_rx)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [7:0]  m_mode, m_baud, m_ctrl, m_port;
  logic [15:0] m_fcr;
  logic        m_tend, m_tde, m_brk, m_rdf, m_dr, m_rxirq, m_txirq;

  function automatic int trig_model(logic [15:0] f);
    case (f[7:6])
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 8'h00; m_baud = 8'hFF; m_ctrl = 8'h20; m_port = 8'h00; m_fcr = 16'h0;
    m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0; m_rxirq = 0; m_txirq = 0;
  endtask

  task automatic step(input bit w, input bit r, input logic [5:0] a, input logic [15:0] wd,
                      input logic [4:0] qc, input logic [7:0] qd,
                      input bit er, input bit ed, input bit eb, input string tag);
    logic [15:0] exp_rd;
    logic [7:0]  ceff;
    bit          exp_pop, exp_tx, exp_flush;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = wd;
    rxq_count = qc; rxq_data = qd;
    ev_rx_ready = er; ev_rx_data = ed; ev_break = eb;
    #1;
    exp_pop = r && a == 6'h14 && qc != 0;
    chk({15'd0, rxq_pop}, {15'd0, exp_pop}, {"R9 pop ", tag});
    case (a)
      6'h00: exp_rd = {8'd0, m_mode};
      6'h04: exp_rd = {8'd0, m_baud};
      6'h08: exp_rd = {8'd0, m_ctrl};
      6'h10: exp_rd = {8'd0, 1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
      6'h14: exp_rd = (qc != 0) ? {8'd0, qd} : 16'd0;
      6'h18: exp_rd = m_fcr;
      6'h1C: exp_rd = {11'd0, qc};
      6'h20: exp_rd = {8'd0, m_port};
      default: exp_rd = 16'd0;
    endcase
    if (!r) exp_rd = 16'd0;
    ceff = (w && a == 6'h08) ? (wd[7:0] & 8'hFA) : m_ctrl;
    exp_tx = 0; exp_flush = 0;
    if (r && a == 6'h10 && m_ctrl[5]) begin m_tend = 1; m_tde = 1; end
    if (exp_pop && (int'(qc) - 1) < trig_model(m_fcr)) m_rdf = 0;
    if (w) begin
      case (a)
        6'h00: m_mode = wd[7:0] & 8'h7B;
        6'h04: m_baud = wd[7:0];
        6'h08: begin
          m_ctrl = wd[7:0] & 8'hFA;
          m_txirq = wd[7];
          if (!wd[5]) m_tend = 1;
          if (!wd[6]) m_rxirq = 0;
        end
        6'h0C: begin m_tde = 0; exp_tx = 1; end
        6'h10: begin
          if (!wd[6]) m_tend = 0;
          if (!wd[5]) m_tde = 0;
          if (!wd[4]) m_brk = 0;
          if (!wd[1]) m_rdf = 0;
          if (!wd[0]) m_dr = 0;
          if (!wd[1] || !wd[0]) m_rxirq = 0;
        end
        6'h18: begin m_fcr = wd; exp_flush = wd[1]; end
        6'h20: m_port = wd[7:0] & 8'hF3;
        default: ;
      endcase
    end
    if (er) m_rdf = 1;
    if (er && ceff[6]) m_rxirq = 1;
    if (ed) m_dr = 1;
    if (eb) m_brk = 1;
    @(posedge clk); #1;
    chk(bus_rdata, exp_rd, {"R3 rdata ", tag});
    chk({15'd0, bus_rvalid}, {15'd0, r}, {"R3 rvalid ", tag});
    chk({15'd0, tx_strobe}, {15'd0, exp_tx}, {"R8 strobe ", tag});
    if (exp_tx) chk({8'd0, tx_byte}, {8'd0, wd[7:0]}, {"R8 byte ", tag});
    chk({15'd0, rxq_flush}, {15'd0, exp_flush}, {"R10 flush ", tag});
    chk({11'd0, rx_trig_level}, 16'(trig_model(m_fcr)), {"R10 trig ", tag});
    chk({15'd0, irq_tx}, {15'd0, m_txirq}, {"R7 irq_tx ", tag});
    chk({15'd0, irq_rx}, {15'd0, m_rxirq}, {"R5 irq_rx ", tag});
    chk({cfg_mode, cfg_baud}, {m_mode, m_baud}, {"R2 cfg mode/baud ", tag});
    chk({cfg_ctrl, cfg_port}, {m_ctrl, m_port}, {"R2 cfg ctrl/port ", tag});
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    step(0, 1, a, 16'h0, 5'd0, 8'h00, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input string tag);
    step(1, 0, a, d, 5'd0, 8'h00, 0, 0, 0, tag);
  endtask

  localparam logic [5:0] OFS [12] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14,
                                      6'h18, 6'h1C, 6'h20, 6'h24, 6'h28, 6'h3E};

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset values, seen through reads and the config outputs
    rd(6'h10, "R1 status after reset");
    rd(6'h04, "R1 baud after reset");
    rd(6'h08, "R1 ctrl after reset");
    rd(6'h18, "R1 fifo ctrl after reset");

    // R2: masks
    wr(6'h00, 16'h00FF, "R2 mode mask");   rd(6'h00, "R2 mode readback");
    wr(6'h20, 16'h00FF, "R2 port mask");   rd(6'h20, "R2 port readback");
    wr(6'h04, 16'h005A, "R2 baud full");   rd(6'h04, "R2 baud readback");
    wr(6'h18, 16'hA5C0, "R2 fcr 16 bit");  rd(6'h18, "R2 fcr readback");
    wr(6'h08, 16'h00FF, "R2 ctrl mask, R7 tie");  rd(6'h08, "R2 ctrl readback");

    // R4 and R3: set all event flags, clear selectively
    step(0, 0, 6'h00, 0, 0, 0, 1, 1, 1, "R4 set events");
    rd(6'h10, "R3 all flags");
    wr(6'h10, 16'h00EF, "R4 clear break only");
    rd(6'h10, "R4 after break clear");
    wr(6'h10, 16'h00FE, "R4 clear dr, R5 irq drop");
    rd(6'h10, "R4 after dr clear");

    // R6: rearm with transmitter off then on
    wr(6'h08, 16'h0040, "R7 ctrl te off sets tend");
    wr(6'h10, 16'h0000, "R4 clear all");
    rd(6'h10, "R6 read te off");
    rd(6'h10, "R6 no rearm");
    wr(6'h08, 16'h0060, "R6 te on");
    wr(6'h10, 16'h0000, "R4 clear all");
    rd(6'h10, "R6 read returns old");
    rd(6'h10, "R6 rearmed");

    // R8: transmit
    wr(6'h0C, 16'h1234, "R8 tx write");
    rd(6'h10, "R8 tde cleared");
    wr(6'h0C, 16'h00A7, "R8 tx again");

    // R9: receive reads, trigger 4
    wr(6'h18, 16'h0040, "R10 trig 4");
    step(0, 0, 6'h00, 0, 0, 0, 1, 0, 0, "R5 rx ready with rie");
    step(0, 1, 6'h14, 0, 5'd5, 8'h3C, 0, 0, 0, "R9 pop keeps rdf");
    step(0, 1, 6'h14, 0, 5'd4, 8'h3D, 0, 0, 0, "R9 pop clears rdf");
    step(0, 1, 6'h14, 0, 5'd0, 8'h77, 0, 0, 0, "R9 empty read");
    step(0, 1, 6'h1C, 0, 5'd16, 8'h00, 0, 0, 0, "R9 count read");
    rd(6'h10, "R9 status");
    wr(6'h18, 16'h00C2, "R10 trig 14 and flush");
    wr(6'h18, 16'h0080, "R10 trig 8");

    // R12: event vs clearing write in same cycle
    step(1, 0, 6'h10, 16'h0000, 0, 0, 1, 1, 1, "R12 set beats clear");
    rd(6'h10, "R12 flags survive");
    // R5: control write drops rie while event arrives
    step(1, 0, 6'h08, 16'h0020, 0, 0, 1, 0, 0, "R5 rie off with event");
    step(1, 0, 6'h08, 16'h0060, 0, 0, 1, 0, 0, "R5 rie on with event");

    // R11: inert offsets
    wr(6'h24, 16'hFFFF, "R11 lsr write");
    wr(6'h28, 16'h0000, "R11 unmapped write");
    wr(6'h3E, 16'h0000, "R11 unmapped write 2");
    rd(6'h24, "R11 lsr read");
    rd(6'h0C, "R11 txd read");
    rd(6'h3E, "R11 unmapped read");
    rd(6'h10, "R11 status unchanged");
    rd(6'h18, "R11 fcr unchanged");

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int kind;
      bit w, r;
      kind = $urandom_range(0, 2);
      w = (kind == 1);
      r = (kind == 2);
      step(w, r, OFS[$urandom_range(0, 11)], 16'($urandom()),
           5'($urandom_range(0, 16)), 8'($urandom()),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 9) == 0), "random");
    end

    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule